// File: doc/BRIEF.md
# Video Sync Clamp Window Generator

This block decides, sample by sample, when the DC-restore clamp of a three-channel analog video path should be active. It watches one of two sync sources: the sync-detect bit from the luma/green sync stripper, or an external sync pin. From that source it produces a clamp enable, a flag that tells the clamp whether it is restoring the sync tip or the blanking level, and a sync-loss status.

With bi-level sync (standard definition, progressive and filter bypass), the clamp acts on the sync tip while the pulse lasts. With tri-level sync (high definition), the sync tip is too short to clamp on. The end of a width-qualified pulse therefore starts a back-porch timer, and the block clamps the blanking level for a configurable number of samples. Long vertical broad pulses do not qualify. An external source is qualified against a per-format minimum width, so short glitches are ignored. In high definition mode with an external source, the pin level itself defines the window.

Format and source selection are sampled only at a sync leading edge. If no qualified pulse arrives within a configurable timeout, the sync-loss flag is raised and the clamp is held off until a qualified pulse returns.

Top module: `vsc_clamp_window`

## Requirements
- R1: After reset, clamp_en_o is 0 and sync_lost_o is 1. Both stay that way until the first qualified sync pulse.
- R2: When src_ext_i is 1, only ext_sync_i drives the timing. When src_ext_i is 0, only strip_sync_i drives it. Pulses on the unselected input produce no clamp.
- R3: In the bi-level formats (fmt_i 00, 01 and 11) with the internal source, clamp_en_o is high for exactly as many cycles as the sync pulse, and clamp_blank_o is 0 while it is high.
- R4: In tri-level format (fmt_i 10) with the internal source, the clamp stays low during the pulse. After a qualified pulse ends, clamp_en_o is high for exactly HD_PORCH_LEN cycles, with clamp_blank_o at 1.
- R5: In tri-level format with the internal source, a pulse of up to HD_PULSE_MAX samples qualifies. A longer pulse, such as a broad pulse, produces no clamp.
- R6: With the external source in a bi-level format, a pulse of W samples yields W-M+1 clamp cycles when W is at least M, and none otherwise. M is EXT_MIN_SD for format 00 and EXT_MIN_PS for formats 01 and 11. A pulse shorter than M does not count as qualified.
- R7: In tri-level format with the external source, the pin level defines the window directly, with no timer. A pulse of W samples yields W-EXT_MIN_HD+1 clamp cycles with clamp_blank_o at 1, and none if W is less than EXT_MIN_HD.
- R8: A change on fmt_i or src_ext_i takes effect only at the next leading edge of the selected sync input. A back-porch window still running at that edge ends there.
- R9: sync_lost_o rises about LOSS_TIMEOUT cycles after the last qualified pulse. While it is high, clamp_en_o is 0. It clears on the next qualified pulse.
- R10: Both sync inputs pass through a two-flop synchronizer. With the internal source in a bi-level format, clamp_en_o rises at the third rising clock edge after the sync input rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strip_sync_i | input | 1 | Sync-detect bit from the luma/green sync stripper (asynchronous) |
| ext_sync_i | input | 1 | External sync pin (asynchronous) |
| src_ext_i | input | 1 | Sync source select: 1 selects the external pin, 0 selects the stripper |
| fmt_i | input | 2 | Format select: 00 SD, 01 progressive, 10 HD tri-level, 11 bypass (bi-level) |
| clamp_en_o | output | 1 | Clamp enable |
| clamp_blank_o | output | 1 | Clamp target: 1 is the blanking level, 0 is the sync tip |
| sync_lost_o | output | 1 | No qualified sync within the timeout |

## Verification
The properties assume that fmt_i and src_ext_i are quasi-static control levels that never change in the same cycle as a sync leading edge. They also assume that each sync input holds a level for several samples, rather than toggling every clock. The stimulus changes the select pins only during idle gaps between pulses, at the falling clock edge. It drives every sync pulse as a multi-cycle level, and it keeps the spacing between qualified pulses well under the loss timeout except in the loss test itself.

// File: rtl/vsc_pkg.sv
`timescale 1ns/1ps
package vsc_pkg;

  // Format select codes; the tri-level code is the only one that
  // switches the clamp to the back-porch scheme.
  typedef enum logic [1:0] {
    FMT_SD  = 2'b00,
    FMT_PS  = 2'b01,
    FMT_HD  = 2'b10,
    FMT_BYP = 2'b11
  } fmt_e;

  function automatic logic is_trilevel(input fmt_e f);
    return f == FMT_HD;
  endfunction

endpackage

// File: rtl/vsc_sync2.sv
`timescale 1ns/1ps
module vsc_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [1:0] stg;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[0], d[b]};
    end
    assign q[b] = stg[1];
  end

endmodule

// File: rtl/vsc_pulse_meas.sv
`timescale 1ns/1ps
module vsc_pulse_meas
  import vsc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_int,
  input  logic             s_ext,
  input  logic             src_pin,
  input  fmt_e             fmt_pin,
  output logic             rise,
  output logic             fall,
  output logic             lvl,
  output logic             m_src,
  output fmt_e             m_fmt,
  output fmt_e             act_fmt,
  output logic [CNT_W-1:0] cur_w,
  output logic [CNT_W-1:0] prev_w
);

  logic             cand, cand_q, lvl_q, act_src;
  logic [CNT_W-1:0] wcnt;

  // Leading edges are looked for on the input named by the live select pin.
  assign cand  = src_pin ? s_ext : s_int;
  assign rise  = cand & ~cand_q;

  // The mode for this cycle: newly sampled pins at an edge, latched otherwise.
  assign m_src = rise ? src_pin : act_src;
  assign m_fmt = rise ? fmt_pin : act_fmt;
  assign lvl   = m_src ? s_ext : s_int;
  assign fall  = lvl_q & ~lvl;

  always_comb begin
    if (!lvl)        cur_w = '0;
    else if (rise)   cur_w = {{(CNT_W-1){1'b0}}, 1'b1};
    else if (&wcnt)  cur_w = wcnt;
    else             cur_w = wcnt + 1'b1;
  end

  assign prev_w = wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q  <= 1'b0;
      lvl_q   <= 1'b0;
      wcnt    <= '0;
      act_src <= 1'b0;
      act_fmt <= FMT_SD;
    end else begin
      cand_q <= cand;
      lvl_q  <= lvl;
      wcnt   <= cur_w;
      if (rise) begin
        act_src <= src_pin;
        act_fmt <= fmt_pin;
      end
    end
  end

endmodule

// File: rtl/vsc_porch_timer.sv
`timescale 1ns/1ps
module vsc_porch_timer #(
  parameter int LEN  = 148,
  parameter int PT_W = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clear,
  output logic active
);

  localparam logic [PT_W-1:0] LEN_V = PT_W'(LEN);

  logic [PT_W-1:0] ptmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ptmr <= '0;
    else if (start)        ptmr <= LEN_V;
    else if (clear)        ptmr <= '0;
    else if (ptmr != '0)   ptmr <= ptmr - 1'b1;
  end

  assign active = (ptmr != '0);

endmodule

// File: rtl/vsc_loss_mon.sv
`timescale 1ns/1ps
module vsc_loss_mon #(
  parameter int LIMIT = 7425,
  parameter int TO_W  = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qual,
  output logic lost_nxt,
  output logic lost
);

  localparam logic [TO_W-1:0] LIM_V = TO_W'(LIMIT);

  logic [TO_W-1:0] tcnt, tcnt_n;

  always_comb begin
    if (qual)               tcnt_n = '0;
    else if (tcnt == LIM_V) tcnt_n = tcnt;
    else                    tcnt_n = tcnt + 1'b1;

    if (qual)                 lost_nxt = 1'b0;
    else if (tcnt_n == LIM_V) lost_nxt = 1'b1;
    else                      lost_nxt = lost;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      lost <= 1'b1;
    end else begin
      tcnt <= tcnt_n;
      lost <= lost_nxt;
    end
  end

endmodule

// File: rtl/vsc_clamp_window.sv
`timescale 1ns/1ps
module vsc_clamp_window
  import vsc_pkg::*;
#(
  parameter int HD_PORCH_LEN = 148,
  parameter int HD_PULSE_MAX = 64,
  parameter int EXT_MIN_SD   = 297,
  parameter int EXT_MIN_PS   = 149,
  parameter int EXT_MIN_HD   = 112,
  parameter int LOSS_TIMEOUT = 7425
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strip_sync_i,
  input  logic       ext_sync_i,
  input  logic       src_ext_i,
  input  logic [1:0] fmt_i,
  output logic       clamp_en_o,
  output logic       clamp_blank_o,
  output logic       sync_lost_o
);

  localparam int MAX_A = (EXT_MIN_SD > EXT_MIN_PS) ? EXT_MIN_SD : EXT_MIN_PS;
  localparam int MAX_B = (EXT_MIN_HD > HD_PULSE_MAX) ? EXT_MIN_HD : HD_PULSE_MAX;
  localparam int WMAX  = ((MAX_A > MAX_B) ? MAX_A : MAX_B) + 1;
  localparam int CNT_W = $clog2(WMAX + 1);

  localparam logic [CNT_W-1:0] THR_SD  = CNT_W'(EXT_MIN_SD);
  localparam logic [CNT_W-1:0] THR_PS  = CNT_W'(EXT_MIN_PS);
  localparam logic [CNT_W-1:0] THR_HD  = CNT_W'(EXT_MIN_HD);
  localparam logic [CNT_W-1:0] PMAX_V  = CNT_W'(HD_PULSE_MAX);
  localparam logic [CNT_W-1:0] THR_ONE = CNT_W'(1);

  logic [1:0]       s_sync;
  logic             rise, fall, lvl, m_src;
  fmt_e             m_fmt, act_fmt;
  logic [CNT_W-1:0] cur_w, prev_w, thr;
  logic             hd_int, qual, qual_lvl, qual_hd;
  logic             porch_act, win, lost_nxt, lost;

  vsc_sync2 #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ext_sync_i, strip_sync_i}),
    .q     (s_sync)
  );

  vsc_pulse_meas #(.CNT_W(CNT_W)) u_meas (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_int   (s_sync[0]),
    .s_ext   (s_sync[1]),
    .src_pin (src_ext_i),
    .fmt_pin (fmt_e'(fmt_i)),
    .rise    (rise),
    .fall    (fall),
    .lvl     (lvl),
    .m_src   (m_src),
    .m_fmt   (m_fmt),
    .act_fmt (act_fmt),
    .cur_w   (cur_w),
    .prev_w  (prev_w)
  );

  // Qualifying width for level-defined windows.
  always_comb begin
    if (!m_src) thr = THR_ONE;
    else begin
      unique case (m_fmt)
        FMT_SD:  thr = THR_SD;
        FMT_HD:  thr = THR_HD;
        default: thr = THR_PS;
      endcase
    end
  end

  assign hd_int   = is_trilevel(m_fmt) && !m_src;
  assign qual_lvl = !hd_int && lvl && (cur_w == thr);
  assign qual_hd  = hd_int && fall && (prev_w <= PMAX_V);
  assign qual     = qual_lvl | qual_hd;

  vsc_porch_timer #(.LEN(HD_PORCH_LEN)) u_porch (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (qual_hd),
    .clear  (rise),
    .active (porch_act)
  );

  vsc_loss_mon #(.LIMIT(LOSS_TIMEOUT)) u_loss (
    .clk      (clk),
    .rst_n    (rst_n),
    .qual     (qual),
    .lost_nxt (lost_nxt),
    .lost     (lost)
  );

  assign win = hd_int ? porch_act : (lvl && (cur_w >= thr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clamp_en_o    <= 1'b0;
      clamp_blank_o <= 1'b0;
    end else begin
      clamp_en_o    <= win && !lost_nxt;
      clamp_blank_o <= is_trilevel(m_fmt);
    end
  end

  assign sync_lost_o = lost;

endmodule

// File: rtl/vsc_clamp_window_chk.sv
`timescale 1ns/1ps
module vsc_clamp_window_chk #(
  parameter int HD_PORCH_LEN = 148
) (
  input logic       clk,
  input logic       rst_n,
  input logic       clamp_en_o,
  input logic       sync_lost_o,
  input logic       rise,
  input logic       lvl,
  input logic       hd_int,
  input logic       qual,
  input logic       porch_act,
  input logic [1:0] act_fmt
);

  localparam int RW = $clog2(HD_PORCH_LEN + 2);
  localparam logic [RW-1:0] RUN_MAX = RW'(HD_PORCH_LEN + 1);

  logic [RW-1:0] porch_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   porch_run <= '0;
    else if (!porch_act)          porch_run <= '0;
    else if (porch_run != RUN_MAX) porch_run <= porch_run + 1'b1;
  end

  p_no_clamp_lost_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_en_o |-> !sync_lost_o);

  p_lost_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_lost_o) |-> $past(qual));

  p_no_tip_clamp_hd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hd_int && lvl && !rise) |=> !clamp_en_o);

  p_tip_follows_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hd_int && !lvl) |=> !clamp_en_o);

  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(act_fmt));

  p_porch_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    porch_run <= RW'(HD_PORCH_LEN));

endmodule

bind vsc_clamp_window vsc_clamp_window_chk #(.HD_PORCH_LEN(HD_PORCH_LEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clamp_en_o  (clamp_en_o),
  .sync_lost_o (sync_lost_o),
  .rise        (rise),
  .lvl         (lvl),
  .hd_int      (hd_int),
  .qual        (qual),
  .porch_act   (porch_act),
  .act_fmt     (act_fmt)
);

// File: tb/test_vsc_clamp_window.sv
`timescale 1ns/1ps
module test_vsc_clamp_window;

  localparam int PORCH = 30;
  localparam int PMAX  = 12;
  localparam int MSD   = 20;
  localparam int MPS   = 10;
  localparam int MHD   = 6;
  localparam int LOSS  = 300;
  localparam int GAP   = 60;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strip_sync = 1'b0;
  logic       ext_sync = 1'b0;
  logic       src_ext = 1'b0;
  logic [1:0] fmt = 2'b00;
  logic       clamp_en, clamp_blank, sync_lost;

  int checks = 0;
  int errors = 0;
  int nt = 0;
  int nb = 0;
  logic smp_clamp;

  always #2.5 clk = ~clk;

  vsc_clamp_window #(
    .HD_PORCH_LEN (PORCH),
    .HD_PULSE_MAX (PMAX),
    .EXT_MIN_SD   (MSD),
    .EXT_MIN_PS   (MPS),
    .EXT_MIN_HD   (MHD),
    .LOSS_TIMEOUT (LOSS)
  ) i_vsc_clamp_window (
    .clk           (clk),
    .rst_n         (rst_n),
    .strip_sync_i  (strip_sync),
    .ext_sync_i    (ext_sync),
    .src_ext_i     (src_ext),
    .fmt_i         (fmt),
    .clamp_en_o    (clamp_en),
    .clamp_blank_o (clamp_blank),
    .sync_lost_o   (sync_lost)
  );

  typedef struct packed {
    logic        pin;   // 0 pulses strip_sync, 1 pulses ext_sync
    logic        src;
    logic [1:0]  fmt;
    logic [7:0]  w;
    logic [7:0]  exp;
    logic        blank;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 2'b00, 8'd15, 8'd15, 1'b0, 4'd3},  // R3 SD tip
    '{1'b0, 1'b0, 2'b01, 8'd8,  8'd8,  1'b0, 4'd3},  // R3 progressive
    '{1'b0, 1'b0, 2'b11, 8'd5,  8'd5,  1'b0, 4'd3},  // R3 bypass
    '{1'b0, 1'b0, 2'b10, 8'd10, 8'd30, 1'b1, 4'd4},  // R4 porch
    '{1'b0, 1'b0, 2'b10, 8'd12, 8'd30, 1'b1, 4'd5},  // R5 at max width
    '{1'b0, 1'b0, 2'b10, 8'd13, 8'd0,  1'b1, 4'd5},  // R5 broad pulse
    '{1'b1, 1'b0, 2'b00, 8'd25, 8'd0,  1'b0, 4'd2},  // R2 ext unselected
    '{1'b1, 1'b1, 2'b00, 8'd25, 8'd6,  1'b0, 4'd6},  // R6 SD ext
    '{1'b1, 1'b1, 2'b00, 8'd19, 8'd0,  1'b0, 4'd6},  // R6 SD too short
    '{1'b1, 1'b1, 2'b01, 8'd10, 8'd1,  1'b0, 4'd6},  // R6 PS at min
    '{1'b1, 1'b1, 2'b11, 8'd9,  8'd0,  1'b0, 4'd6},  // R6 bypass short
    '{1'b1, 1'b1, 2'b11, 8'd14, 8'd5,  1'b0, 4'd6},  // R6 bypass ext
    '{1'b1, 1'b1, 2'b10, 8'd20, 8'd15, 1'b1, 4'd7},  // R7 HD ext window
    '{1'b1, 1'b1, 2'b10, 8'd5,  8'd0,  1'b1, 4'd7},  // R7 HD ext short
    '{1'b0, 1'b1, 2'b00, 8'd15, 8'd0,  1'b0, 4'd2},  // R2 int unselected
    '{1'b0, 1'b0, 2'b00, 8'd7,  8'd7,  1'b0, 4'd2}   // R2 int selected again
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Sample the outputs at the falling edge, then drive the next input levels.
  task automatic cyc(input logic vi, input logic ve);
    @(negedge clk);
    smp_clamp = clamp_en;
    if (clamp_en) begin
      if (clamp_blank) nb++;
      else             nt++;
    end
    strip_sync = vi;
    ext_sync   = ve;
  endtask

  task automatic pulse(input logic pin, input int w, input int gap);
    nt = 0;
    nb = 0;
    for (int k = 0; k < w; k++) cyc(!pin, pin);
    for (int k = 0; k < gap; k++) cyc(1'b0, 1'b0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset
    @(negedge clk);
    chk("R1", "clamp after reset", int'(clamp_en), 0);
    chk("R1", "lost after reset", int'(sync_lost), 1);
    for (int k = 0; k < 20; k++) cyc(1'b0, 1'b0);
    chk("R1", "lost before first pulse", int'(sync_lost), 1);

    // R10: clamp appears at the third rising edge after the input rises
    cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b0);
    chk("R10", "clamp after 1 edge", int'(smp_clamp), 0);
    cyc(1'b1, 1'b0);
    chk("R10", "clamp after 2 edges", int'(smp_clamp), 0);
    cyc(1'b1, 1'b0);
    chk("R10", "clamp after 3 edges", int'(smp_clamp), 1);
    for (int k = 0; k < 40; k++) cyc(1'b0, 1'b0);
    chk("R1", "lost cleared by qualified pulse", int'(sync_lost), 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      src_ext = VEC[i].src;
      fmt     = VEC[i].fmt;
      pulse(VEC[i].pin, int'(VEC[i].w), GAP);
      chk($sformatf("R%0d", VEC[i].req), $sformatf("vector %0d clamp cycles", i),
          nt + nb, int'(VEC[i].exp));
      if (VEC[i].exp != 0)
        chk($sformatf("R%0d", VEC[i].req), $sformatf("vector %0d target cycles", i),
            VEC[i].blank ? nb : nt, int'(VEC[i].exp));
    end

    // R8: format change without a new edge leaves the running porch intact
    src_ext = 1'b0;
    fmt = 2'b10;
    pulse(1'b0, 10, 5);
    fmt = 2'b00;
    for (int k = 0; k < 50; k++) cyc(1'b0, 1'b0);
    chk("R8", "porch kept after late fmt change", nb, PORCH);
    chk("R8", "no tip clamp before new edge", nt, 0);

    // R8: a new edge ten cycles after the HD pulse ends cuts the porch short
    fmt = 2'b10;
    nt = 0;
    nb = 0;
    for (int k = 0; k < 10; k++) cyc(1'b1, 1'b0);
    for (int k = 0; k < 10; k++) cyc(1'b0, 1'b0);
    fmt = 2'b00;
    for (int k = 0; k < 6; k++) cyc(1'b1, 1'b0);
    for (int k = 0; k < 40; k++) cyc(1'b0, 1'b0);
    chk("R8", "porch dropped at new edge", nb, 9);
    chk("R8", "new SD pulse tip clamp", nt, 6);

    // R9: loss timeout, gating and recovery
    pulse(1'b0, 5, 0);
    for (int k = 0; k < 270; k++) cyc(1'b0, 1'b0);
    chk("R9", "lost before timeout", int'(sync_lost), 0);
    for (int k = 0; k < 50; k++) cyc(1'b0, 1'b0);
    chk("R9", "lost after timeout", int'(sync_lost), 1);
    src_ext = 1'b1;
    pulse(1'b1, 10, 40);
    chk("R9", "short ext pulse leaves clamp off", nt + nb, 0);
    chk("R6", "short ext pulse does not clear loss", int'(sync_lost), 1);
    src_ext = 1'b0;
    pulse(1'b0, 6, 20);
    chk("R9", "recovery pulse clamp cycles", nt, 6);
    chk("R9", "lost cleared", int'(sync_lost), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule